// File: doc/BRIEF.md
# Link Bring-Up Supervisor with Gen2 Stall Recovery

This block drives the power-up of a serial link on the controller side. After a start request it turns the link power on and off, enables the reference clock, lets the clock settle, and releases the PHY powerdown and the core reset. It then pulses the endpoint reset and caps the advertised link speed at the first generation. Only after that does it enable the link training state machine. All waiting is counted in microseconds from one prescaled tick, so a test can shrink every interval through parameters.

Once training is enabled, the block polls the link status at a fixed interval. On each poll that does not find the link up, it reads a receiver status register in the PHY through a simple request/acknowledge register port. If the receiver is not valid and the training state shows the lock stage of recovery, the block assumes the speed change has hung. It then sets two receiver override bits in a PHY register, holds them for a fixed time and clears them again. Both changes are read-modify-write. When the link comes up, a sticky flag is raised. If the poll budget runs out first, a failure flag is raised instead.

Top module: `link_bringup_sup`

## Requirements
- R1: In reset, pwr_en=0, refclk_en=0, phy_pd=1, core_rst=1, perst_n=0, ltssm_en=0, phy_req=0, link_up=0, link_fail=0, and gen_cap equals GEN_MAX (default 2).
- R2: Take the clock edge that samples start as cycle 0 and let D=TICK_DIV. pwr_en stays 0 until cycle PWR_US*D and is 1 from then on. refclk_en becomes 1 at cycle 2*PWR_US*D.
- R3: phy_pd and core_rst stay 1 for CLK_US*D cycles after refclk_en rises, then both drop to 0.
- R4: perst_n stays 0 for PERST_US*D cycles after core_rst drops, then rises. ltssm_en rises PERST_US*D cycles after perst_n rises.
- R5: gen_cap reads 4'd1 from the rise of perst_n onward, and always while ltssm_en is 1.
- R6: A poll finds the link up only when dbg_link_up=1 and dbg_in_training=0. link_up then rises one cycle after the poll, so it rises at cycle (2*PWR_US+CLK_US+2*PERST_US)*D+1 when that condition already holds.
- R7: A poll that fails issues one PHY read of address 16'h100D and then waits POLL_US*D cycles. After POLL_MAX failed polls, link_fail rises.
- R8: A stall is detected only when bit 0 of the 16'h100D read data is 0 and ltssm_state equals 6'h0D. In every other case no PHY write is issued.
- R9: On a stall, the block reads 16'h1005 and writes back the value with bits 5 and 3 set (mask 16'h0028). It waits at least OVRD_US*D cycles, reads 16'h1005 again and writes back the value with those bits cleared.
- R10: phy_req stays high, with phy_addr, phy_wr and phy_wdata stable, until the one-cycle phy_ack.
- R11: Once link_up is 1 it stays 1, and start has no effect.
- R12: link_fail stays 1 until start. start then clears it and restarts the sequence, with pwr_en back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin bring-up (accepted when idle or failed) |
| dbg_link_up | input | 1 | Link status: link up |
| dbg_in_training | input | 1 | Link status: training in progress |
| ltssm_state | input | 6 | Current training state code |
| pwr_en | output | 1 | Link power enable |
| refclk_en | output | 1 | Reference clock enable |
| phy_pd | output | 1 | PHY test powerdown |
| core_rst | output | 1 | Controller core reset |
| perst_n | output | 1 | Endpoint reset, active low |
| gen_cap | output | 4 | Maximum link speed advertised |
| ltssm_en | output | 1 | Training state machine enable |
| phy_req | output | 1 | PHY register access request |
| phy_wr | output | 1 | 1 = write, 0 = read |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | PHY write data |
| phy_ack | input | 1 | One-cycle access acknowledge |
| phy_rdata | input | 16 | PHY read data, valid with phy_ack |
| link_up | output | 1 | Sticky link-up flag |
| link_fail | output | 1 | Bring-up timed out |

## Verification
Every delay is a whole number of D-cycle microseconds, counted from the edge that accepts start or that enters a phase. The bench therefore resets a cycle counter at that edge, samples at falling edges, and checks each output one cycle before and exactly at the cycle where it is due: 10/20/36/48/60 with the shortened bench parameters. A link-up poll answers one cycle after training is enabled. Each failed poll without a stall costs 8 cycles, so the timeout lands at cycle 92. The override hold is checked as a window of at least OVRD_US*D cycles between the two write acknowledges. That window allows for the few handshake cycles of the second read.

// File: rtl/link_bringup_sup.sv
module link_bringup_sup #(
  parameter int          TICK_DIV    = 125,
  parameter int          PWR_US      = 20000,
  parameter int          CLK_US      = 50000,
  parameter int          PERST_US    = 20000,
  parameter int          POLL_US     = 10,
  parameter int          POLL_MAX    = 4000,
  parameter int          OVRD_US     = 3000,
  parameter logic [3:0]  GEN_MAX     = 4'd2,
  parameter logic [15:0] RXSTAT_ADDR = 16'h100D,
  parameter logic [15:0] OVRD_ADDR   = 16'h1005,
  parameter logic [15:0] OVRD_MASK   = 16'h0028,
  parameter logic [5:0]  STUCK_STATE = 6'h0D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        dbg_link_up,
  input  logic        dbg_in_training,
  input  logic [5:0]  ltssm_state,
  output logic        pwr_en,
  output logic        refclk_en,
  output logic        phy_pd,
  output logic        core_rst,
  output logic        perst_n,
  output logic [3:0]  gen_cap,
  output logic        ltssm_en,
  output logic        phy_req,
  output logic        phy_wr,
  output logic [15:0] phy_addr,
  output logic [15:0] phy_wdata,
  input  logic        phy_ack,
  input  logic [15:0] phy_rdata,
  output logic        link_up,
  output logic        link_fail
);
  localparam int PW = $clog2(TICK_DIV + 1);
  localparam int UW = $clog2(PWR_US + CLK_US + PERST_US + POLL_US + OVRD_US + 1);
  localparam int CW = $clog2(POLL_MAX + 1);

  typedef enum logic [3:0] {
    IDLE, PWR_LO, PWR_HI, CLK_ON, PERST_LO, PERST_HI, POLL, RX_RD,
    OV_RD1, OV_WR1, OV_HOLD, OV_RD2, OV_WR2, POLL_WAIT, UP, FAIL
  } st_t;

  st_t st, nxt;
  logic [PW-1:0] pre;
  logic [UW-1:0] us, tgt;
  logic [CW-1:0] polls;
  logic [15:0]   rd_q;

  wire tick    = pre == PW'(TICK_DIV - 1);
  wire done    = tick && (us == tgt - 1'b1);
  wire link_ok = dbg_link_up && !dbg_in_training;
  wire stuck   = !phy_rdata[0] && (ltssm_state == STUCK_STATE);

  always_comb begin
    case (st)
      PWR_LO, PWR_HI:   tgt = UW'(PWR_US);
      CLK_ON:           tgt = UW'(CLK_US);
      PERST_LO, PERST_HI: tgt = UW'(PERST_US);
      OV_HOLD:          tgt = UW'(OVRD_US);
      default:          tgt = UW'(POLL_US);
    endcase
  end

  always_comb begin
    nxt = st;
    case (st)
      IDLE:      if (start) nxt = PWR_LO;
      PWR_LO:    if (done) nxt = PWR_HI;
      PWR_HI:    if (done) nxt = CLK_ON;
      CLK_ON:    if (done) nxt = PERST_LO;
      PERST_LO:  if (done) nxt = PERST_HI;
      PERST_HI:  if (done) nxt = POLL;
      POLL:      nxt = link_ok ? UP : RX_RD;
      RX_RD:     if (phy_ack) nxt = stuck ? OV_RD1 : POLL_WAIT;
      OV_RD1:    if (phy_ack) nxt = OV_WR1;
      OV_WR1:    if (phy_ack) nxt = OV_HOLD;
      OV_HOLD:   if (done) nxt = OV_RD2;
      OV_RD2:    if (phy_ack) nxt = OV_WR2;
      OV_WR2:    if (phy_ack) nxt = POLL_WAIT;
      POLL_WAIT: if (done) nxt = (polls == CW'(POLL_MAX - 1)) ? FAIL : POLL;
      UP:        nxt = UP;
      FAIL:      if (start) nxt = PWR_LO;
      default:   nxt = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      pre   <= '0;
      us    <= '0;
      polls <= '0;
      rd_q  <= '0;
    end else begin
      st <= nxt;
      if (nxt != st) begin
        pre <= '0;
        us  <= '0;
      end else if (tick) begin
        pre <= '0;
        us  <= us + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
      if (nxt == PWR_LO && st != PWR_LO) polls <= '0;
      else if (st == POLL_WAIT && done)  polls <= polls + 1'b1;
      if ((st == OV_RD1 || st == OV_RD2) && phy_ack) rd_q <= phy_rdata;
    end
  end

  assign pwr_en    = !(st inside {IDLE, PWR_LO});
  assign refclk_en = !(st inside {IDLE, PWR_LO, PWR_HI});
  assign phy_pd    = st inside {IDLE, PWR_LO, PWR_HI, CLK_ON};
  assign core_rst  = st inside {IDLE, PWR_LO, PWR_HI, CLK_ON};
  assign perst_n   = st >= PERST_HI;
  assign gen_cap   = (st >= PERST_HI) ? 4'd1 : GEN_MAX;
  assign ltssm_en  = (st >= POLL) && (st != FAIL);
  assign phy_req   = st inside {RX_RD, OV_RD1, OV_WR1, OV_RD2, OV_WR2};
  assign phy_wr    = st inside {OV_WR1, OV_WR2};
  assign phy_addr  = (st == RX_RD) ? RXSTAT_ADDR : OVRD_ADDR;
  assign phy_wdata = (st == OV_WR1) ? (rd_q | OVRD_MASK) : (rd_q & ~OVRD_MASK);
  assign link_up   = st == UP;
  assign link_fail = st == FAIL;

  assert_clk_before_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst |-> refclk_en && pwr_en);
  assert_train_after_perst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ltssm_en |-> perst_n && !core_rst && !phy_pd);
  assert_gen1_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ltssm_en |-> gen_cap == 4'd1);
  assert_up_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> $past(dbg_link_up && !dbg_in_training));
  assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && !phy_ack |=> phy_req && $stable(phy_addr) && $stable(phy_wr) && $stable(phy_wdata));
  assert_up_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |=> link_up);
  assert_fail_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail && !start |=> link_fail);
  assert_fail_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail && start |=> !link_fail && !pwr_en);
endmodule

// File: tb/link_bringup_sup_bench.sv
module link_bringup_sup_bench;
  localparam int D = 2;
  logic clk = 0, rst_n = 0, start = 0;
  logic dbg_link_up = 0, dbg_in_training = 0;
  logic [5:0] ltssm_state = 0;
  logic pwr_en, refclk_en, phy_pd, core_rst, perst_n, ltssm_en;
  logic [3:0] gen_cap;
  logic phy_req, phy_wr, phy_ack = 0;
  logic [15:0] phy_addr, phy_wdata, phy_rdata = 0;
  logic link_up, link_fail;

  int total = 0, bad = 0, t = 0, cyc_n = 0;
  int nrx = 0, nwr = 0, t1 = 0, t2 = 0;
  logic [15:0] w1 = 0, w2 = 0, w1_addr = 0;
  logic [15:0] rx_reg = 16'h0001, ovrd_reg = 16'h010C;

  always #4 clk = ~clk;

  link_bringup_sup #(.TICK_DIV(D), .PWR_US(5), .CLK_US(8), .PERST_US(6),
    .POLL_US(3), .POLL_MAX(4), .OVRD_US(7)) u_link_bringup_sup (
    .clk(clk), .rst_n(rst_n), .start(start), .dbg_link_up(dbg_link_up),
    .dbg_in_training(dbg_in_training), .ltssm_state(ltssm_state),
    .pwr_en(pwr_en), .refclk_en(refclk_en), .phy_pd(phy_pd), .core_rst(core_rst),
    .perst_n(perst_n), .gen_cap(gen_cap), .ltssm_en(ltssm_en), .phy_req(phy_req),
    .phy_wr(phy_wr), .phy_addr(phy_addr), .phy_wdata(phy_wdata), .phy_ack(phy_ack),
    .phy_rdata(phy_rdata), .link_up(link_up), .link_fail(link_fail));

  always @(negedge clk) begin
    cyc_n++;
    if (phy_req && !phy_ack) begin
      phy_ack = 1;
      if (phy_wr) begin
        ovrd_reg = phy_wdata;
        nwr++;
        if (nwr == 1) begin w1 = phy_wdata; t1 = cyc_n; w1_addr = phy_addr; end
        if (nwr == 2) begin w2 = phy_wdata; t2 = cyc_n; end
      end else if (phy_addr == 16'h100D) begin
        nrx++;
        phy_rdata = rx_reg;
      end else begin
        phy_rdata = ovrd_reg;
      end
    end else begin
      phy_ack = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_to(input int k);
    while (t < k) begin @(negedge clk); t++; end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; start = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    t = 0; nrx = 0; nwr = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R1 pwr_en", pwr_en, 0);
    chk("R1 refclk_en", refclk_en, 0);
    chk("R1 phy_pd", phy_pd, 1);
    chk("R1 core_rst", core_rst, 1);
    chk("R1 perst_n", perst_n, 0);
    chk("R1 ltssm_en", ltssm_en, 0);
    chk("R1 phy_req", phy_req, 0);
    chk("R1 flags", {link_up, link_fail}, 0);
    chk("R1 gen_cap", gen_cap, 2);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_sequence_up();
    dbg_link_up = 1; dbg_in_training = 0;
    pulse_start();
    wait_to(9);  chk("R2 pwr_en low phase", pwr_en, 0);
    wait_to(10); chk("R2 pwr_en high", pwr_en, 1);
    wait_to(19); chk("R2 refclk_en before", refclk_en, 0);
    wait_to(20); chk("R2 refclk_en on", refclk_en, 1);
    wait_to(35); chk("R3 core_rst held", {core_rst, phy_pd}, 2'b11);
    wait_to(36); chk("R3 core_rst/phy_pd released", {core_rst, phy_pd}, 2'b00);
    chk("R5 gen_cap before perst release", gen_cap, 2);
    wait_to(47); chk("R4 perst_n low", perst_n, 0);
    wait_to(48); chk("R4 perst_n high", perst_n, 1);
    chk("R5 gen_cap forced", gen_cap, 1);
    wait_to(59); chk("R4 ltssm_en before", ltssm_en, 0);
    wait_to(60); chk("R4 ltssm_en on", ltssm_en, 1);
    chk("R6 link_up not yet", link_up, 0);
    wait_to(61); chk("R6 link_up", link_up, 1);
    chk("R6 no phy read when up", nrx, 0);
    pulse_start();
    wait_to(3);
    chk("R11 link_up after start", link_up, 1);
    chk("R11 pwr_en after start", pwr_en, 1);
  endtask

  task automatic t_training_timeout();
    do_reset();
    dbg_link_up = 1; dbg_in_training = 1; rx_reg = 16'h0001; ltssm_state = 6'h0D;
    pulse_start();
    wait_to(91); chk("R7 link_fail before budget", link_fail, 0);
    wait_to(92); chk("R7 link_fail at budget", link_fail, 1);
    chk("R6 in-training blocks up", link_up, 0);
    chk("R7 status reads", nrx, 4);
    chk("R8 valid receiver no write", nwr, 0);
    wait_to(100); chk("R12 fail sticky", link_fail, 1);
  endtask

  task automatic t_wrong_state();
    dbg_link_up = 0; dbg_in_training = 0; rx_reg = 16'h0000; ltssm_state = 6'h0C;
    pulse_start();
    wait_to(1);
    chk("R12 fail cleared", link_fail, 0);
    chk("R12 power cycled", pwr_en, 0);
    wait_to(92); chk("R7 fail again", link_fail, 1);
    chk("R8 other state no write", nwr, 0);
  endtask

  task automatic t_stuck();
    rx_reg = 16'h0000; ltssm_state = 6'h0D; ovrd_reg = 16'h010C;
    pulse_start();
    while (!link_fail && t < 3000) begin @(negedge clk); t++; end
    chk("R9 fail reached", link_fail, 1);
    chk("R9 writes per stuck poll", nwr, 8);
    chk("R9 set value", w1, 16'h012C);
    chk("R9 clear value", w2, 16'h0104);
    chk("R9 final register", ovrd_reg, 16'h0104);
    chk("R9 hold min", (t2 - t1) >= 14, 1);
    chk("R9 hold max", (t2 - t1) <= 18, 1);
    chk("R10 write address", w1_addr, 16'h1005);
    chk("R10 status reads", nrx, 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired (all requirements)");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sequence_up();
    t_training_timeout();
    t_wrong_state();
    t_stuck();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule